// File: doc/BRIEF.md
# ISDN Transceiver Activation Sequencer

This block sequences power-down, wake-up and clock gating for an S-interface line transceiver whose control side is a GCI (IOM-style) serial port. It watches an asynchronous line signal-detect input, the level of the GCI data line and the GCI frame strobe. It also takes decoded C/I commands, a full-frame-synchronization flag from the receiver and a clock keep-alive pin. From these it drives the crystal oscillator enable, the internal clock distribution enable, the transceiver enable, GCI clock/frame enable, a request to pull the GCI data line low, and a permit for realigning the GCI frame to the received line frame.

The wake-up path and the power policy depend on a static mode strap. A network-side termination wakes its controller by pulling the data line low before any clock exists. It then holds the transceiver clocks off for a fixed number of GCI frames while the crystal settles. A terminal wakes on line activity or on a timing request from its controller, and may keep its clocks alive in power-down. The two line-termination modes keep every clock running and only switch the transceiver itself on and off.

Top module: `isdn_act_seq`

## Requirements
- R1: Mode strap encodings are 00 network termination (NT), 01 terminal (TE), 10 line termination S-side (LT-S) and 11 line termination T-side (LT-T). The strap is only changed while reset is asserted. After reset in NT mode with no line signal, every output is low.
- R2: In NT mode in power-down, a high signal-detect drives the data-line pull-low output high at once, with no clock edge needed. After synchronization the request is held, even if the detect drops, until an activate or deactivate command arrives.
- R3: In NT mode, an activate command (C/I code 4'h8) turns on the crystal and GCI clock/frame on the next cycle and releases the pull-low. Clock distribution and transceiver enable stay low until 16 GCI frame strobes have been counted, and rise within two cycles of the sixteenth.
- R4: In NT mode the crystal enable is low whenever the block is in power-down.
- R5: In TE mode, a synchronized signal-detect moves the block from power-down straight to the hunting/active state: crystal, GCI clock, clock distribution and transceiver are all enabled.
- R6: In TE mode, a low level on the GCI data line (timing request) enables crystal, GCI clock/frame and clock distribution with the transceiver still off. A following activate command turns the transceiver on.
- R7: In TE mode in power-down, the crystal, GCI clock and clock distribution enables follow the keep-alive input. The transceiver stays off.
- R8: In LT-S and LT-T modes, the crystal, GCI clock and clock distribution enables are high at all times, including in power-down.
- R9: In LT modes a deactivate command disables only the transceiver. Signal detect or an activate command enables it again.
- R10: The frame-realignment permit is high only in TE mode, with the transceiver active and the full-sync flag high.
- R11: A deactivate command (C/I code 4'hF) clears the transceiver enable on the next cycle in every mode. Clock enables that fall do so at least one cycle after the transceiver enable has fallen.
- R12: Commands with any other code, and any code presented with the command-valid strobe low, leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Mode strap (see R1) |
| sdet_async | input | 1 | Asynchronous line signal-detect |
| dl_async | input | 1 | Asynchronous GCI data-line level (low = timing request) |
| frame_strobe | input | 1 | One-cycle GCI frame pulse |
| cmd_valid | input | 1 | C/I command strobe |
| cmd_code | input | 4 | Decoded C/I command code |
| s_sync | input | 1 | Receiver has full line-frame synchronization |
| keep_clk | input | 1 | Request to keep clocks alive in power-down (TE) |
| xtal_en | output | 1 | Crystal oscillator enable |
| clk_dist_en | output | 1 | Internal clock distribution enable |
| sx_en | output | 1 | Line transceiver enable |
| dl_pull_low | output | 1 | Request to pull the GCI data line low |
| gci_clk_en | output | 1 | GCI clock/frame enable |
| realign_ok | output | 1 | Permit to realign GCI frame to line frame |

## Verification
The assertions watch, on every cycle, the properties that are rules of ordering: the transceiver enable never rises without the crystal already on in NT mode, clock distribution in NT mode rises only once the frame counter reports completion, and clocks never fall in the same cycle as the transceiver enable. They also check that the frame counter stays within its bound and clears outside the settling phase, that a deactivate always removes the transceiver, and that the realignment permit implies sync. The asynchronous pull-low response, the exact count of sixteen frames, the timing-request and keep-alive paths and the immunity to foreign codes can only be shown by the bench's scenarios. The same holds for long mixed command sequences in the TE and LT modes.

// File: rtl/isdn_act_pkg.sv
package isdn_act_pkg;

  typedef enum logic [1:0] {
    MODE_NT  = 2'd0,
    MODE_TE  = 2'd1,
    MODE_LTS = 2'd2,
    MODE_LTT = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_DOWN   = 3'd0,
    ST_REQ    = 3'd1,
    ST_SETTLE = 3'd2,
    ST_RUN    = 3'd3,
    ST_DROP   = 3'd4
  } state_e;

endpackage

// File: rtl/isdn_act_sync.sv
module isdn_act_sync #(
  parameter int             W       = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {2{RST_VAL[i]}};
      else        stg <= {stg[0], d[i]};
    end
    assign q[i] = stg[1];
  end

endmodule

// File: rtl/isdn_act_frame_timer.sv
module isdn_act_frame_timer #(
  parameter int FRAME_CNT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic frame_strobe,
  output logic done
);

  localparam int CNT_W = $clog2(FRAME_CNT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAME_CNT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Count only while settling; any other state returns the count to zero
  assign cnt_en = !run || (frame_strobe && (cnt_q != LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (!run)            cnt_d = '0;
    else if (cnt_en)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIMIT);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/isdn_act_fsm.sv
module isdn_act_fsm
  import isdn_act_pkg::*;
#(
  parameter int               CMD_W     = 4,
  parameter logic [CMD_W-1:0] CMD_ACT   = 4'h8,
  parameter logic [CMD_W-1:0] CMD_DEACT = 4'hF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             sdet_raw,
  input  logic             sdet_s,
  input  logic             dl_low_s,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             s_sync,
  input  logic             keep_clk,
  input  logic             settle_done,
  output logic             settle_run,
  output logic             xtal_en,
  output logic             gci_clk_en,
  output logic             clk_dist_en,
  output logic             sx_en,
  output logic             dl_pull_low,
  output logic             realign_ok
);

  mode_e  m;
  state_e st_q, st_d;
  logic   act, deact, awake;

  assign m     = mode_e'(mode);
  assign act   = cmd_valid && (cmd_code == CMD_ACT);
  assign deact = cmd_valid && (cmd_code == CMD_DEACT);

  // Next-state process
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DOWN: begin
        if (act)                          st_d = (m == MODE_NT) ? ST_SETTLE : ST_RUN;
        else if (sdet_s)                  st_d = (m == MODE_NT) ? ST_REQ    : ST_RUN;
        else if (m == MODE_TE && dl_low_s) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (deact)    st_d = ST_DOWN;
        else if (act) st_d = (m == MODE_NT) ? ST_SETTLE : ST_RUN;
      end
      ST_SETTLE: begin
        if (deact)            st_d = ST_DOWN;
        else if (settle_done) st_d = ST_RUN;
      end
      ST_RUN:  if (deact) st_d = ST_DROP;
      ST_DROP: st_d = ST_DOWN;
      default: st_d = ST_DOWN;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_DOWN;
    else        st_q <= st_d;
  end

  assign settle_run = (st_q == ST_SETTLE);
  assign awake      = (st_q != ST_DOWN);

  // Output decode per mode
  always_comb begin
    xtal_en     = 1'b1;
    gci_clk_en  = 1'b1;
    clk_dist_en = 1'b1;
    dl_pull_low = 1'b0;
    unique case (m)
      MODE_NT: begin
        xtal_en     = st_q inside {ST_SETTLE, ST_RUN, ST_DROP};
        gci_clk_en  = st_q inside {ST_SETTLE, ST_RUN, ST_DROP};
        clk_dist_en = st_q inside {ST_RUN, ST_DROP};
        // raw detect path works with no clock running
        dl_pull_low = (st_q == ST_REQ) || ((st_q == ST_DOWN) && sdet_raw);
      end
      MODE_TE: begin
        xtal_en     = awake || keep_clk;
        gci_clk_en  = awake || keep_clk;
        clk_dist_en = awake || keep_clk;
      end
      default: ;
    endcase
  end

  assign sx_en      = (st_q == ST_RUN);
  assign realign_ok = (m == MODE_TE) && (st_q == ST_RUN) && s_sync;

  p_dist_after_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m == MODE_NT && $rose(clk_dist_en)) |-> $past(settle_done));

  p_nt_xtal_before_sx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m == MODE_NT && $rose(sx_en)) |-> $past(xtal_en));

  p_deact_sx_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_DEACT) |=> !sx_en);

  p_xtal_after_sx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xtal_en) |-> !$past(sx_en));

  p_dist_after_sx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_dist_en) |-> !$past(sx_en));

  p_lt_clk_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && $fell(sx_en)) |=> (xtal_en && gci_clk_en && clk_dist_en));

endmodule

// File: rtl/isdn_act_seq.sv
module isdn_act_seq
  import isdn_act_pkg::*;
#(
  parameter int               FRAME_CNT = 16,
  parameter int               CMD_W     = 4,
  parameter logic [CMD_W-1:0] CMD_ACT   = 4'h8,
  parameter logic [CMD_W-1:0] CMD_DEACT = 4'hF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             sdet_async,
  input  logic             dl_async,
  input  logic             frame_strobe,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             s_sync,
  input  logic             keep_clk,
  output logic             xtal_en,
  output logic             clk_dist_en,
  output logic             sx_en,
  output logic             dl_pull_low,
  output logic             gci_clk_en,
  output logic             realign_ok
);

  logic [1:0] rst_stg;
  logic       rst_ns;
  logic       sdet_s, dl_s;
  logic       settle_run, settle_done;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_stg <= 2'b00;
    else        rst_stg <= {rst_stg[0], 1'b1};
  end
  assign rst_ns = rst_stg[1];

  isdn_act_sync #(.W(2), .RST_VAL(2'b10)) i_sync (
    .clk   (clk),
    .rst_n (rst_ns),
    .d     ({dl_async, sdet_async}),
    .q     ({dl_s, sdet_s})
  );

  isdn_act_frame_timer #(.FRAME_CNT(FRAME_CNT)) i_timer (
    .clk          (clk),
    .rst_n        (rst_ns),
    .run          (settle_run),
    .frame_strobe (frame_strobe),
    .done         (settle_done)
  );

  isdn_act_fsm #(
    .CMD_W     (CMD_W),
    .CMD_ACT   (CMD_ACT),
    .CMD_DEACT (CMD_DEACT)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_ns),
    .mode        (mode),
    .sdet_raw    (sdet_async),
    .sdet_s      (sdet_s),
    .dl_low_s    (!dl_s),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .s_sync      (s_sync),
    .keep_clk    (keep_clk),
    .settle_done (settle_done),
    .settle_run  (settle_run),
    .xtal_en     (xtal_en),
    .gci_clk_en  (gci_clk_en),
    .clk_dist_en (clk_dist_en),
    .sx_en       (sx_en),
    .dl_pull_low (dl_pull_low),
    .realign_ok  (realign_ok)
  );

  p_realign_gate_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    realign_ok |-> (s_sync && sx_en && mode == 2'b01));

endmodule

// File: tb/test_isdn_act_seq.sv
module test_isdn_act_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       sdet_async, dl_async, frame_strobe, cmd_valid, s_sync, keep_clk;
  logic [3:0] cmd_code;
  logic       xtal_en, clk_dist_en, sx_en, dl_pull_low, gci_clk_en, realign_ok;

  int  n_chk  = 0;
  int  n_fail = 0;
  int  cyc    = 0;
  bit  ended  = 0;

  localparam logic [3:0] C_ACT   = 4'h8;
  localparam logic [3:0] C_DEACT = 4'hF;

  always #5 clk = ~clk;

  isdn_act_seq i_isdn_act_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sdet_async(sdet_async),
    .dl_async(dl_async), .frame_strobe(frame_strobe), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .s_sync(s_sync), .keep_clk(keep_clk),
    .xtal_en(xtal_en), .clk_dist_en(clk_dist_en), .sx_en(sx_en),
    .dl_pull_low(dl_pull_low), .gci_clk_en(gci_clk_en), .realign_ok(realign_ok)
  );

  // {xtal, gci, dist, sx, pull, realign}
  wire [5:0] outs = {xtal_en, gci_clk_en, clk_dist_en, sx_en, dl_pull_low, realign_ok};

  task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [1:0] md);
    @(negedge clk);
    rst_n = 1'b0; mode = md;
    sdet_async = 1'b0; dl_async = 1'b1; frame_strobe = 1'b0;
    cmd_valid = 1'b0; cmd_code = 4'h0; s_sync = 1'b0; keep_clk = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  task automatic send_cmd(input logic [3:0] c, input logic v);
    @(negedge clk);
    cmd_valid = v; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'h0;
    #1;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
  endtask

  // Reference model for the random phase: 0 power-down, 1 active, 2 dropping
  function automatic logic [5:0] exp_out(input logic [1:0] md, input int st,
                                         input logic keep, input logic syn);
    logic c;
    if (md[1]) return {3'b111, st == 1, 1'b0, 1'b0};
    c = (st != 0) || keep;
    return {c, c, c, st == 1, 1'b0, (st == 1) && syn};
  endfunction

  function automatic int next_st(input int st, input logic v, input logic [3:0] c);
    if (st == 0 && v && c == C_ACT)   return 1;
    if (st == 1 && v && c == C_DEACT) return 2;
    if (st == 2)                      return 0;
    return st;
  endfunction

  task automatic random_phase(input logic [1:0] md, input string req, input int n);
    int st = 0;
    do_reset(md);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = ($urandom % 4) == 0;
      case ($urandom % 3)
        0:       cmd_code = C_ACT;
        1:       cmd_code = C_DEACT;
        default: cmd_code = 4'h5;
      endcase
      s_sync   = $urandom % 2;
      keep_clk = (md == 2'b01) ? 1'($urandom % 2) : 1'b0;
      #1;
      chk(req, outs, exp_out(md, st, keep_clk, s_sync));
      st = next_st(st, cmd_valid, cmd_code);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !ended) begin
      ended = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;

    // NT mode
    do_reset(2'b00);
    chk("R1", outs, 6'b000000);
    @(negedge clk); sdet_async = 1'b1; #1;
    chk("R2", outs, 6'b000010);          // no clock edge yet
    wait_n(5);
    chk("R4", outs, 6'b000010);
    @(negedge clk); sdet_async = 1'b0;
    wait_n(3);
    chk("R2", outs, 6'b000010);          // request held
    send_cmd(C_ACT, 1'b1);
    chk("R3", outs, 6'b110000);
    for (int k = 0; k < 15; k++) pulse_frame();
    wait_n(3);
    chk("R3", outs, 6'b110000);          // 15 frames: still held off
    pulse_frame();
    wait_n(2);
    chk("R3", outs, 6'b111100);
    send_cmd(4'h3, 1'b1);
    chk("R12", outs, 6'b111100);
    send_cmd(C_DEACT, 1'b0);
    chk("R12", outs, 6'b111100);
    send_cmd(C_DEACT, 1'b1);
    chk("R11", outs, 6'b111000);         // transceiver first
    wait_n(1);
    chk("R11", outs, 6'b000000);
    chk("R4", outs, 6'b000000);
    send_cmd(C_ACT, 1'b1);               // controller-side wake
    chk("R3", outs, 6'b110000);
    send_cmd(C_DEACT, 1'b1);
    chk("R4", outs, 6'b000000);

    // TE mode
    do_reset(2'b01);
    chk("R7", outs, 6'b000000);
    @(negedge clk); keep_clk = 1'b1; #1;
    chk("R7", outs, 6'b111000);
    @(negedge clk); keep_clk = 1'b0; #1;
    chk("R7", outs, 6'b000000);
    @(negedge clk); dl_async = 1'b0;
    wait_n(4);
    chk("R6", outs, 6'b111000);
    send_cmd(C_ACT, 1'b1);
    chk("R6", outs, 6'b111100);
    chk("R10", outs, 6'b111100);
    @(negedge clk); s_sync = 1'b1; #1;
    chk("R10", outs, 6'b111101);
    @(negedge clk); s_sync = 1'b0; dl_async = 1'b1;
    wait_n(4);
    send_cmd(C_DEACT, 1'b1);
    chk("R11", outs, 6'b111000);
    wait_n(1);
    chk("R11", outs, 6'b000000);
    @(negedge clk); sdet_async = 1'b1;
    wait_n(4);
    chk("R5", outs, 6'b111100);
    @(negedge clk); sdet_async = 1'b0;
    wait_n(3);
    send_cmd(C_DEACT, 1'b1);
    wait_n(1);
    chk("R5", outs, 6'b000000);

    // LT-S mode
    do_reset(2'b10);
    chk("R8", outs, 6'b111000);
    @(negedge clk); sdet_async = 1'b1;
    wait_n(4);
    chk("R9", outs, 6'b111100);
    @(negedge clk); sdet_async = 1'b0; s_sync = 1'b1;
    wait_n(3);
    chk("R10", outs, 6'b111100);
    send_cmd(C_DEACT, 1'b1);
    chk("R9", outs, 6'b111000);
    wait_n(2);
    chk("R8", outs, 6'b111000);
    send_cmd(C_ACT, 1'b1);
    chk("R9", outs, 6'b111100);

    // Mixed command sequences
    random_phase(2'b01, "R7", 400);
    random_phase(2'b11, "R9", 400);
    random_phase(2'b10, "R12", 200);

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule